// File: doc/BRIEF.md
# Debug Event Pin Controller

This block sits beside an on-chip emulation unit and owns a small group of bidirectional debug event pins: six numbered pins plus one extra pin tied to the data-value detection channel. Each pin has a two-bit role field in a 16-bit control register. As an input, a pin can hold its matching detection channel enabled and can fire debug actions: a request to enter debug state, a debug exception, a trace start or a trace stop. Pin 4 can also be turned into an output that tells an external host that the core has put a word in the debug transmit register. The host uses it as an interrupt and clears it by finishing its read over the test port.

Inputs pass through a synchroniser. Channel enables follow the synchronised level. Events are single-cycle pulses on its rising edge, gated per pin and per event by a separate mask register. A level request for debug state is raised from pin 0. After reset this request lasts for as long as the pin stays high. Later it is raised only while the core reports that it is idle. Detection channels, trace logic, the test port and the core are outside this block and appear only as strobes.

Top module: `dbgpin_ctrl`

## Requirements
- R1: After reset the control register reads 16'hFFFF and the mask register reads 28'h0000001. Every pin is an input (`pin_oe_o` is all zero), and the transmit flag is clear.
- R2: When `cfg_we_i` is high, the register chosen by `cfg_sel_i` is written at the next clock edge (0 = control register, lower 16 bits of `cfg_wdata_i`; 1 = mask register, 28 bits). All bits are kept, including the reserved bits 15:14. `cfg_rdata_o` returns the chosen register, zero-extended.
- R3: The role field of pin n sits in control bits [2n+1:2n], and the data-channel pin is n = 6. Encodings: 00 = ignored, 01 = channel enable, 10 = output, 11 = channel enable plus events (the reset default). With role 01 or 11, `chan_en_o[n]` equals the pin level delayed by two clock edges.
- R4: With role 11, a rising edge of the synchronised pin n produces a one-cycle pulse on each event output whose mask bit is set. Mask bit 4n+e selects event e, where e = 0 is debug entry, 1 is exception, 2 is trace on and 3 is trace off. Pulses from all pins are ORed. The same pin can enable its channel and fire events in the same cycle.
- R5: With role 10, `pin_oe_o[n]` is high. Pin 4 then drives the transmit flag on `pin_out_o[4]`. Every other output-role pin drives 0, and so does every pin that is not in output role.
- R6: The transmit flag is set by `tx_wr_i` and cleared by `tx_rd_done_i`, with the change visible after the next edge. If both strobes arrive in the same cycle, set wins.
- R7: `dbg_hold_o` is high when synchronised pin 0 is high, its role is 11 and mask bit 0 is set, and either the boot window is open or `core_idle_i` is high. The boot window opens at reset and closes once synchronised pin 0 has been seen low after the synchroniser has filled.
- R8: A pin whose role is 00 or 10 has no effect. Level changes on it produce no channel enable and no event pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 1 | Register select: 0 control, 1 mask |
| cfg_wdata_i | input | 28 | Write data |
| cfg_rdata_o | output | 28 | Read data of the selected register |
| pin_in_i | input | 7 | Pin input levels (bit 6 = data-channel pin) |
| pin_out_o | output | 7 | Pin output levels |
| pin_oe_o | output | 7 | Pin output enables |
| tx_wr_i | input | 1 | Core wrote the transmit register |
| tx_rd_done_i | input | 1 | Host finished reading the transmit register |
| core_idle_i | input | 1 | Core is in wait or stop |
| chan_en_o | output | 7 | Detection channel enables (bit 6 = data channel) |
| ev_dbg_o | output | 1 | Debug-entry event pulse |
| ev_exc_o | output | 1 | Debug exception event pulse |
| ev_trc_on_o | output | 1 | Trace enable event pulse |
| ev_trc_off_o | output | 1 | Trace disable event pulse |
| dbg_hold_o | output | 1 | Level request for debug state from pin 0 |

## Verification
The assertions assume that register writes and strobes are synchronous to `clk`. They also assume that the pin inputs carry clean 0/1 levels once they are past the synchroniser. The bench changes every input only on the falling clock edge. Before each random pattern it returns all pins to low and lets the synchroniser settle, so every rising edge it checks starts from a known previous level. It reprograms the registers only while the pins are low, so a role change never lines up with a pin edge.

// File: rtl/dbgpin_pkg.sv
package dbgpin_pkg;

    localparam int NPIN    = 7;
    localparam int FW      = 2;
    localparam int NEV     = 4;
    localparam int CTRL_W  = 16;
    localparam int MASK_W  = NPIN * NEV;
    localparam int BUS_W   = (CTRL_W > MASK_W) ? CTRL_W : MASK_W;
    localparam int TX_PIN  = 4;
    localparam int BOOT_PIN = 0;

    localparam logic [CTRL_W-1:0] CTRL_RST = '1;
    localparam logic [MASK_W-1:0] MASK_RST = MASK_W'(1);

    typedef enum logic [FW-1:0] {
        PM_OFF  = 2'b00,
        PM_CHAN = 2'b01,
        PM_OUT  = 2'b10,
        PM_FULL = 2'b11
    } pin_mode_e;

    typedef struct packed {
        logic trc_off;
        logic trc_on;
        logic exc;
        logic dbg;
    } ev_t;

    function automatic pin_mode_e mode_of(input logic [CTRL_W-1:0] ctrl, input int n);
        return pin_mode_e'(ctrl[FW*n +: FW]);
    endfunction

    function automatic logic mode_listens(input pin_mode_e m);
        return (m == PM_CHAN) || (m == PM_FULL);
    endfunction

endpackage

// File: rtl/dbgpin_sync.sv
module dbgpin_sync #(
    parameter int W = 1,
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int i = 1; i < N; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q_o = stage_q[N-1];
endmodule

// File: rtl/dbgpin_regs.sv
module dbgpin_regs
    import dbgpin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic              sel_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output logic [BUS_W-1:0]  rdata_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [MASK_W-1:0] mask_o
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [MASK_W-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
            mask_q <= MASK_RST;
        end else if (we_i) begin
            if (sel_i) mask_q <= wdata_i[MASK_W-1:0];
            else       ctrl_q <= wdata_i[CTRL_W-1:0];
        end
    end

    always_comb begin
        rdata_o = '0;
        if (sel_i) rdata_o[MASK_W-1:0] = mask_q;
        else       rdata_o[CTRL_W-1:0] = ctrl_q;
    end

    assign ctrl_o = ctrl_q;
    assign mask_o = mask_q;
endmodule

// File: rtl/dbgpin_txflag.sv
module dbgpin_txflag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)        flag_q <= 1'b0;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/dbgpin_lane.sv
module dbgpin_lane
    import dbgpin_pkg::*;
(
    input  pin_mode_e      mode_i,
    input  logic [NEV-1:0] mask_i,
    input  logic           lvl_i,
    input  logic           prev_i,
    output logic           chan_o,
    output ev_t            ev_o,
    output logic           oe_o
);
    logic rise;

    always_comb begin
        rise   = lvl_i & ~prev_i;
        chan_o = lvl_i & mode_listens(mode_i);
        oe_o   = (mode_i == PM_OUT);
        ev_o   = '0;
        if (rise && mode_i == PM_FULL) ev_o = ev_t'(mask_i);
    end
endmodule

// File: rtl/dbgpin_ctrl.sv
module dbgpin_ctrl
    import dbgpin_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we_i,
    input  logic             cfg_sel_i,
    input  logic [BUS_W-1:0] cfg_wdata_i,
    output logic [BUS_W-1:0] cfg_rdata_o,
    input  logic [NPIN-1:0]  pin_in_i,
    output logic [NPIN-1:0]  pin_out_o,
    output logic [NPIN-1:0]  pin_oe_o,
    input  logic             tx_wr_i,
    input  logic             tx_rd_done_i,
    input  logic             core_idle_i,
    output logic [NPIN-1:0]  chan_en_o,
    output logic             ev_dbg_o,
    output logic             ev_exc_o,
    output logic             ev_trc_on_o,
    output logic             ev_trc_off_o,
    output logic             dbg_hold_o
);
    localparam int CW = $clog2(SYNC_N + 1);

    logic [CTRL_W-1:0] ctrl_q;
    logic [MASK_W-1:0] mask_q;
    logic [NPIN-1:0]   lvl, prev_q;
    logic              tx_flag;
    ev_t               lane_ev [NPIN];
    ev_t               ev_all;
    logic [CW-1:0]     settle_q;
    logic              boot_q;

    dbgpin_regs u_regs (
        .clk(clk), .rst(rst), .we_i(cfg_we_i), .sel_i(cfg_sel_i),
        .wdata_i(cfg_wdata_i), .rdata_o(cfg_rdata_o),
        .ctrl_o(ctrl_q), .mask_o(mask_q)
    );

    dbgpin_sync #(.W(NPIN), .N(SYNC_N)) u_sync (
        .clk(clk), .rst(rst), .d_i(pin_in_i), .q_o(lvl)
    );

    dbgpin_txflag u_tx (
        .clk(clk), .rst(rst), .set_i(tx_wr_i), .clr_i(tx_rd_done_i), .flag_o(tx_flag)
    );

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    for (genvar n = 0; n < NPIN; n++) begin : g_lane
        dbgpin_lane u_lane (
            .mode_i(mode_of(ctrl_q, n)),
            .mask_i(mask_q[NEV*n +: NEV]),
            .lvl_i(lvl[n]),
            .prev_i(prev_q[n]),
            .chan_o(chan_en_o[n]),
            .ev_o(lane_ev[n]),
            .oe_o(pin_oe_o[n])
        );
        if (n == TX_PIN) begin : g_tx
            assign pin_out_o[n] = pin_oe_o[n] & tx_flag;
        end else begin : g_zero
            assign pin_out_o[n] = 1'b0;
        end
    end

    always_comb begin
        ev_all = '0;
        for (int n = 0; n < NPIN; n++) ev_all = ev_all | lane_ev[n];
    end

    assign ev_dbg_o     = ev_all.dbg;
    assign ev_exc_o     = ev_all.exc;
    assign ev_trc_on_o  = ev_all.trc_on;
    assign ev_trc_off_o = ev_all.trc_off;

    // boot window: closes once the synchroniser has filled and pin 0 reads low
    always_ff @(posedge clk) begin
        if (rst) begin
            settle_q <= '0;
            boot_q   <= 1'b1;
        end else begin
            if (settle_q != CW'(SYNC_N)) settle_q <= settle_q + 1'b1;
            else if (!lvl[BOOT_PIN])      boot_q   <= 1'b0;
        end
    end

    assign dbg_hold_o = lvl[BOOT_PIN]
                      & (mode_of(ctrl_q, BOOT_PIN) == PM_FULL)
                      & mask_q[NEV*BOOT_PIN]
                      & (boot_q | core_idle_i);
endmodule

// File: rtl/dbgpin_ctrl_chk.sv
module dbgpin_ctrl_chk
    import dbgpin_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_we_i,
    input logic              cfg_sel_i,
    input logic [BUS_W-1:0]  cfg_wdata_i,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic              tx_wr_i,
    input logic              tx_rd_done_i,
    input logic              tx_flag,
    input logic [NPIN-1:0]   pin_oe_o,
    input logic [NPIN-1:0]   chan_en_o
);
    AST_RST_INPUTS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> pin_oe_o == '0);  // R1

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cfg_we_i && !cfg_sel_i) |=> ctrl_q == $past(cfg_wdata_i[CTRL_W-1:0]));  // R2

    AST_TX_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        tx_wr_i |=> tx_flag);  // R6

    AST_TX_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (tx_rd_done_i && !tx_wr_i) |=> !tx_flag);  // R6

    AST_OUT_NO_CHAN: assert property (@(posedge clk) disable iff (rst)
        (pin_oe_o & chan_en_o) == '0);  // R8
endmodule

bind dbgpin_ctrl dbgpin_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
    .cfg_wdata_i(cfg_wdata_i), .ctrl_q(ctrl_q), .tx_wr_i(tx_wr_i),
    .tx_rd_done_i(tx_rd_done_i), .tx_flag(tx_flag),
    .pin_oe_o(pin_oe_o), .chan_en_o(chan_en_o)
);

// File: tb/dbgpin_ctrl_test.sv
module dbgpin_ctrl_test;
    import dbgpin_pkg::*;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_we_i = 1'b0;
    logic             cfg_sel_i = 1'b0;
    logic [BUS_W-1:0] cfg_wdata_i = '0;
    logic [BUS_W-1:0] cfg_rdata_o;
    logic [NPIN-1:0]  pin_in_i = '0;
    logic [NPIN-1:0]  pin_out_o, pin_oe_o, chan_en_o;
    logic             tx_wr_i = 1'b0, tx_rd_done_i = 1'b0, core_idle_i = 1'b0;
    logic             ev_dbg_o, ev_exc_o, ev_trc_on_o, ev_trc_off_o, dbg_hold_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dbgpin_ctrl uut (
        .clk(clk), .rst(rst), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
        .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
        .pin_in_i(pin_in_i), .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o),
        .tx_wr_i(tx_wr_i), .tx_rd_done_i(tx_rd_done_i), .core_idle_i(core_idle_i),
        .chan_en_o(chan_en_o), .ev_dbg_o(ev_dbg_o), .ev_exc_o(ev_exc_o),
        .ev_trc_on_o(ev_trc_on_o), .ev_trc_off_o(ev_trc_off_o), .dbg_hold_o(dbg_hold_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [BUS_W-1:0] d);
        cfg_sel_i = sel; cfg_wdata_i = d; cfg_we_i = 1'b1;
        cyc(1);
        cfg_we_i = 1'b0;
    endtask

    function automatic logic [1:0] fld(input logic [15:0] c, input int n);
        return c[2*n +: 2];
    endfunction

    function automatic logic [NPIN-1:0] exp_chan(input logic [15:0] c, input logic [NPIN-1:0] p);
        logic [NPIN-1:0] r = '0;
        for (int n = 0; n < NPIN; n++)
            r[n] = p[n] && (fld(c, n) == 2'b01 || fld(c, n) == 2'b11);
        return r;
    endfunction

    function automatic logic [3:0] exp_ev(input logic [15:0] c, input logic [27:0] m,
                                          input logic [NPIN-1:0] p);
        logic [3:0] r = '0;
        for (int n = 0; n < NPIN; n++)
            if (p[n] && fld(c, n) == 2'b11) r = r | m[4*n +: 4];
        return r;
    endfunction

    function automatic logic [NPIN-1:0] exp_oe(input logic [15:0] c);
        logic [NPIN-1:0] r = '0;
        for (int n = 0; n < NPIN; n++) r[n] = (fld(c, n) == 2'b10);
        return r;
    endfunction

    function automatic logic [3:0] evs();
        return {ev_trc_off_o, ev_trc_on_o, ev_exc_o, ev_dbg_o};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] c;
        logic [27:0] m;
        logic [NPIN-1:0] p;
        void'($urandom(32'h5EED_1234));

        // reset with pin 0 held high (boot debug entry)
        pin_in_i = 7'b0000001;
        cyc(3);
        rst = 1'b0;
        cyc(5);
        cfg_sel_i = 1'b0; #1;
        chk("R1 ctrl reset", cfg_rdata_o, 32'h0000FFFF);
        cfg_sel_i = 1'b1; #1;
        chk("R1 mask reset", cfg_rdata_o, 32'h1);
        chk("R1 oe reset", pin_oe_o, 0);
        chk("R1 out reset", pin_out_o, 0);
        chk("R7 boot hold", dbg_hold_o, 1);
        chk("R3 default chan", chan_en_o, 7'b0000001);

        // release pin 0: boot window closes
        pin_in_i = '0;
        cyc(3);
        chk("R7 hold released", dbg_hold_o, 0);
        pin_in_i = 7'b0000001;
        cyc(2);
        chk("R7 no hold when running", dbg_hold_o, 0);
        chk("R4 dbg pulse pin0", evs(), 4'b0001);
        cyc(1);
        chk("R4 pulse single", evs(), 4'b0000);
        core_idle_i = 1'b1; #1;
        chk("R7 hold while idle", dbg_hold_o, 1);
        core_idle_i = 1'b0;
        pin_in_i = '0;
        cyc(3);

        // transmit flag on pin 4 as output
        wr(1'b1, 28'hFFFFFFF);
        c = 16'hFEFF;
        wr(1'b0, {12'h0, c});
        cfg_sel_i = 1'b0; #1;
        chk("R2 ctrl readback", cfg_rdata_o, {16'h0, c});
        chk("R5 oe pin4", pin_oe_o, 7'b0010000);
        chk("R5 out idle", pin_out_o, 0);
        tx_wr_i = 1'b1; cyc(1); tx_wr_i = 1'b0; #1;
        chk("R6 flag set", pin_out_o, 7'b0010000);
        tx_rd_done_i = 1'b1; cyc(1); tx_rd_done_i = 1'b0; #1;
        chk("R6 flag clear", pin_out_o, 0);
        tx_wr_i = 1'b1; cyc(1); tx_wr_i = 1'b0; #1;
        tx_rd_done_i = 1'b1; tx_wr_i = 1'b1; cyc(1);
        tx_rd_done_i = 1'b0; tx_wr_i = 1'b0; #1;
        chk("R6 set wins", pin_out_o, 7'b0010000);
        pin_in_i = 7'b0010000;
        cyc(2);
        chk("R8 output pin no chan", chan_en_o, 0);
        chk("R8 output pin no event", evs(), 0);
        pin_in_i = '0;
        cyc(3);

        // role 00 ignored on pin 2
        c = 16'hFFCF;
        wr(1'b0, {12'h0, c});
        pin_in_i = 7'b0000100;
        cyc(2);
        chk("R8 off pin no chan", chan_en_o, 0);
        chk("R8 off pin no event", evs(), 0);
        pin_in_i = '0;
        cyc(3);

        // random roles, masks and pin patterns
        for (int it = 0; it < 60; it++) begin
            c = 16'($urandom);
            m = 28'($urandom);
            if (it % 5 == 0) c = 16'hFFFF;
            wr(1'b0, {12'h0, c});
            wr(1'b1, m);
            cfg_sel_i = 1'b1; #1;
            chk("R2 mask readback", cfg_rdata_o, {4'h0, m});
            cfg_sel_i = 1'b0; #1;
            chk("R2 ctrl readback rand", cfg_rdata_o, {16'h0, c});
            chk("R5 oe rand", pin_oe_o, exp_oe(c));
            cyc(2);
            p = 7'($urandom);
            pin_in_i = p;
            cyc(1);
            chk("R3 chan not yet", chan_en_o, 0);
            cyc(1);
            chk("R3 chan rand", chan_en_o, exp_chan(c, p));
            chk("R4 events rand", evs(), exp_ev(c, m, p));
            cyc(1);
            chk("R4 events one cycle", evs(), 0);
            chk("R3 chan held", chan_en_o, exp_chan(c, p));
            pin_in_i = '0;
            cyc(3);
        end
        finish_run();
    end
endmodule